// File: doc/BRIEF.md
# Shared-Bus Start-Up Ownership Synchronizer

Each processor on a shared external bus carries one copy of this block. After a system reset it settles which node owns the bus first and brings the local arbitration record in line with the other nodes. Node 1 is the default owner. It raises its request line during reset and for two cycles afterwards, and it enables the memory strobe drivers only while no other node requested the bus on the previous cycle. All other nodes keep their request line low.

Every node watches the full request vector. On the first post-reset cycle where exactly one line is high, the node marks itself synchronized and records that line's node number as the current master. If node 1 is not synchronized when its two-cycle window closes, it lowers its request and its strobe enable. It leaves them low from then on, because later arbitration belongs to other logic. Node number 0 stands for a system with a single processor: the block reports synchronized and enables the strobes as soon as reset ends.

Top module: `arbSyncTop`

## Requirements
- R1: A node whose number is not 1 never asserts `reqOut`, neither during reset nor after it.
- R2: Node 1 holds `reqOut` high after a reset clock edge and through the first two clock cycles after `rst` falls, whatever the other lines do.
- R3: Request bit k stands for node k+1. When `rst` is low and exactly one bit is high on a cycle where `synced` is low, the next edge sets `synced` and loads `masterId` with that node number.
- R4: A cycle with zero lines or several lines high leaves `synced` and `masterId` unchanged. Once set, `synced` stays set until reset, and `masterId` no longer changes.
- R5: For node 1, `strobeEn` is high only when `reqOut` is high and no request bit other than bit 0 was high on the previous cycle.
- R6: If node 1 is not synchronized by the edge that closes its two-cycle window, `reqOut` and `strobeEn` go low on that edge and stay low until the next reset.
- R7: If node 1 is synchronized by that edge, it keeps `reqOut` high and stays bus owner.
- R8: With node number 0, `synced` is 1 and `masterId` is 0 after reset. Whenever `rst` is low, `strobeEn` is 1 and `reqOut` is 0.
- R9: A node with a non-zero number cannot synchronize while `rst` is high, even if only one line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| procId | input | 3 | This node's number (0 = single processor) |
| reqIn | input | 6 | All bus request lines, bit k = node k+1, active high |
| reqOut | output | 1 | This node's request line |
| strobeEn | output | 1 | Enable for the read, write and memory-select drivers |
| masterId | output | 3 | Recorded bus master, valid while `synced` is high |
| synced | output | 1 | Sticky synchronized status |

## Verification
The hardest case to reach is node 1 losing its default ownership: two or more lines must stay high through both window cycles and then clear, so that the drop can be seen on its own. The vector table reaches this by driving two external requests across the whole window. One entry shows node 1 dropping and staying unsynchronized. A second entry leaves a single line standing after the drop, so node 1 synchronizes to another master. The bench feeds node 1's own `reqOut` back into bit 0, which makes the strobe gating depend on the block's real output.

// File: rtl/arbSyncPkg.sv
package arbSyncPkg;
  // control strobes from the sequencer to the datapath
  typedef struct packed {
    logic sampleEn;   // post-reset cycle: sync detection allowed
    logic windowEnd;  // last cycle of the start-up ownership window
  } ctrlStrobes_t;
endpackage

// File: rtl/arbSyncCtrl.sv
module arbSyncCtrl
  import arbSyncPkg::*;
#(
  parameter int ID_W    = 3,
  parameter int WIN_LEN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] procId,
  input  logic            syncNext,
  input  logic            othersPrev,
  output ctrlStrobes_t    strobes,
  output logic            reqOut,
  output logic            strobeEn
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_LEN - 1);
  localparam logic [CNT_W-1:0] WIN_DONE = CNT_W'(WIN_LEN);

  logic [CNT_W-1:0] postCnt;
  logic             holdReq;
  logic             isOwner;
  logic             isSingle;

  assign isOwner  = (procId == ID_W'(1));
  assign isSingle = (procId == '0);

  assign strobes.sampleEn  = !rst;
  assign strobes.windowEnd = !rst && (postCnt == WIN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      postCnt <= '0;
      holdReq <= isOwner;
    end else begin
      if (postCnt != WIN_DONE) postCnt <= postCnt + 1'b1;
      if (strobes.windowEnd) holdReq <= holdReq && syncNext;
    end
  end

  assign reqOut = holdReq;

  always_comb begin
    if (isSingle) strobeEn = !rst;
    else          strobeEn = isOwner && holdReq && !othersPrev;
  end
endmodule

// File: rtl/arbSyncPath.sv
module arbSyncPath
  import arbSyncPkg::*;
#(
  parameter int NODES = 6,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  procId,
  input  logic [NODES-1:0] reqIn,
  input  ctrlStrobes_t     strobes,
  output logic             synced,
  output logic [ID_W-1:0]  masterId,
  output logic             othersPrev,
  output logic             syncNext
);
  localparam int HIT_W = $clog2(NODES + 1);

  logic [NODES-1:0] othersMask;
  logic [HIT_W-1:0] hitCnt;
  logic [ID_W-1:0]  hitId;
  logic             oneHit;

  for (genvar g = 0; g < NODES; g++) begin : g_mask
    assign othersMask[g] = (procId != ID_W'(g + 1));
  end

  always_comb begin
    hitCnt = '0;
    hitId  = '0;
    for (int i = 0; i < NODES; i++) begin
      if (reqIn[i]) begin
        hitCnt = hitCnt + 1'b1;
        hitId  = ID_W'(i + 1);
      end
    end
  end

  assign oneHit   = (hitCnt == HIT_W'(1));
  assign syncNext = synced || (strobes.sampleEn && oneHit);

  always_ff @(posedge clk) begin
    if (rst) begin
      synced   <= (procId == '0);
      masterId <= '0;
    end else if (strobes.sampleEn && !synced && oneHit) begin
      synced   <= 1'b1;
      masterId <= hitId;
    end
  end

  // previous-cycle view of the other nodes, kept through reset
  always_ff @(posedge clk) othersPrev <= |(reqIn & othersMask);
endmodule

// File: rtl/arbSyncTop.sv
module arbSyncTop
  import arbSyncPkg::*;
#(
  parameter int NODES   = 6,
  parameter int ID_W    = 3,
  parameter int WIN_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  procId,
  input  logic [NODES-1:0] reqIn,
  output logic             reqOut,
  output logic             strobeEn,
  output logic [ID_W-1:0]  masterId,
  output logic             synced
);
  ctrlStrobes_t strobes;
  logic         syncNext;
  logic         othersPrev;

  arbSyncCtrl #(.ID_W(ID_W), .WIN_LEN(WIN_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .procId(procId), .syncNext(syncNext),
    .othersPrev(othersPrev), .strobes(strobes), .reqOut(reqOut),
    .strobeEn(strobeEn)
  );

  arbSyncPath #(.NODES(NODES), .ID_W(ID_W)) u_path (
    .clk(clk), .rst(rst), .procId(procId), .reqIn(reqIn),
    .strobes(strobes), .synced(synced), .masterId(masterId),
    .othersPrev(othersPrev), .syncNext(syncNext)
  );
endmodule

// File: rtl/arbSyncChk.sv
module arbSyncChk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] procId,
  input logic [5:0] reqIn,
  input logic       reqOut,
  input logic       strobeEn,
  input logic [2:0] masterId,
  input logic       synced
);
  p_quiet_req_r1: assert property (@(posedge clk) disable iff (rst)
    procId != 3'd1 |-> !reqOut);

  p_one_sync_r3: assert property (@(posedge clk) disable iff (rst)
    !synced && $countones(reqIn) == 1 |=> synced);

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    synced |=> synced && $stable(masterId));

  p_strobe_gate_r5: assert property (@(posedge clk) disable iff (rst)
    procId == 3'd1 && strobeEn |-> reqOut && !$past(|reqIn[5:1]));

  p_drop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    procId == 3'd1 && !reqOut |=> !reqOut && !strobeEn);

  p_single_r8: assert property (@(posedge clk) disable iff (rst)
    procId == 3'd0 |-> synced && strobeEn && !reqOut);
endmodule

bind arbSyncTop arbSyncChk u_chk (.*);

// File: tb/test_arbSyncTop.sv
module test_arbSyncTop;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] procId = 3'd1;
  logic [5:0] ext = '0;
  logic [5:0] reqIn;
  logic       reqOut, strobeEn, synced;
  logic [2:0] masterId;
  int nChk = 0;
  int nErr = 0;

  always #10 clk = ~clk;

  // node 1 sees its own request on bit 0
  assign reqIn = ext | ((procId == 3'd1 && reqOut) ? 6'b000001 : 6'b000000);

  arbSyncTop i_arbSyncTop (
    .clk(clk), .rst(rst), .procId(procId), .reqIn(reqIn),
    .reqOut(reqOut), .strobeEn(strobeEn), .masterId(masterId), .synced(synced)
  );

  // id, window cycle 0, window cycle 1, following cycle, synced, master, req, strobe
  localparam logic [26:0] VEC [9] = '{
    {3'd1, 6'b000000, 6'b000000, 6'b000000, 1'b1, 3'd1, 1'b1, 1'b1},
    {3'd1, 6'b000010, 6'b000000, 6'b000000, 1'b1, 3'd1, 1'b1, 1'b1},
    {3'd1, 6'b000010, 6'b000100, 6'b000000, 1'b0, 3'd0, 1'b0, 1'b0},
    {3'd1, 6'b000110, 6'b000110, 6'b000100, 1'b1, 3'd3, 1'b0, 1'b0},
    {3'd3, 6'b000000, 6'b000000, 6'b000000, 1'b0, 3'd0, 1'b0, 1'b0},
    {3'd3, 6'b000001, 6'b000000, 6'b000000, 1'b1, 3'd1, 1'b0, 1'b0},
    {3'd2, 6'b100001, 6'b100000, 6'b000001, 1'b1, 3'd6, 1'b0, 1'b0},
    {3'd0, 6'b000011, 6'b000000, 6'b000000, 1'b1, 3'd0, 1'b0, 1'b1},
    {3'd1, 6'b000000, 6'b000010, 6'b000010, 1'b1, 3'd1, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic enterReset(input logic [2:0] id, input logic [5:0] e);
    rst = 1'b1; procId = id; ext = e;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int v = 0; v < 9; v++) begin
      logic [2:0] id;
      id = VEC[v][26:24];
      enterReset(id, 6'b0);
      check($sformatf("R9 v%0d reset synced", v), synced, id == 3'd0);
      check($sformatf("R1 R2 v%0d reset reqOut", v), reqOut, id == 3'd1);
      check($sformatf("R5 v%0d reset strobeEn", v), strobeEn, id == 3'd1);
      rst = 1'b0; ext = VEC[v][23:18];
      check($sformatf("R1 R2 v%0d window0 reqOut", v), reqOut, id == 3'd1);
      @(negedge clk); ext = VEC[v][17:12];
      check($sformatf("R1 R2 v%0d window1 reqOut", v), reqOut, id == 3'd1);
      @(negedge clk); ext = VEC[v][11:6];
      @(negedge clk);
      check($sformatf("R3 R4 v%0d synced", v), synced, VEC[v][5]);
      check($sformatf("R3 R4 R8 v%0d masterId", v), masterId, VEC[v][4:2]);
      check($sformatf("R6 R7 v%0d reqOut", v), reqOut, VEC[v][1]);
      check($sformatf("R5 R6 R8 v%0d strobeEn", v), strobeEn, VEC[v][0]);
    end

    // R5: strobe gating on the previous cycle's other requests
    enterReset(3'd1, 6'b000010);
    check("R5 other line in reset blocks strobe", strobeEn, 0);
    check("R2 reqOut high in reset", reqOut, 1);
    rst = 1'b0; ext = 6'b0;
    check("R5 strobe still blocked first cycle", strobeEn, 0);
    @(negedge clk);
    check("R5 strobe after quiet cycle", strobeEn, 1);
    check("R3 node 1 synced to itself", masterId, 1);
    ext = 6'b000100;
    @(negedge clk);
    check("R5 strobe drops after other request", strobeEn, 0);
    check("R7 owner keeps request", reqOut, 1);
    ext = 6'b0;
    @(negedge clk);
    check("R5 strobe returns", strobeEn, 1);

    // R9 then R3/R4 for a non-owner node
    enterReset(3'd4, 6'b001000);
    check("R9 no sync during reset", synced, 0);
    rst = 1'b0; ext = 6'b0;
    @(negedge clk);
    check("R4 zero lines keep unsynced", synced, 0);
    ext = 6'b010000;
    @(negedge clk);
    check("R3 sync to node 5", synced, 1);
    check("R3 master is node 5", masterId, 5);
    ext = 6'b001000;
    @(negedge clk);
    check("R4 master unchanged", masterId, 5);
    check("R1 node 4 request low", reqOut, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule